// File: doc/BRIEF.md
# Iterative Factorial Register Unit

This block is a small peripheral on a 32-bit register port. It holds a fixed identification word and a liveness register that returns the inverse of what software wrote. Its main part is a factorial engine. Software writes an operand into the operand/result register. The engine then runs one multiply per clock and writes the factorial back into that same register. While the engine runs, a busy bit in the status register reads as one. Software polls that bit, or sets an enable bit so that completion raises an interrupt.

Completion also drives a one-cycle `done_pulse` output. When the enable is set, that pulse latches bit 0 of an interrupt status register. The level output `irq` stays high until software writes the bit to the acknowledge offset. The register port has no back-pressure. A write with `wr_en` high is taken on the rising edge in the cycle it is presented. `rd_data` is a combinational function of `rd_addr` and the current state. Results wrap modulo 2^32, and there is no overflow flag.

Top module: `factorial_unit`

## Requirements
- R1: Reading offset 0x00 returns {major[7:0], minor[7:0], 8'h00, 8'hED}, with the version bytes set by parameters (defaults 0x01 and 0x00, giving 0x010000ED). Writes to 0x00 have no effect.
- R2: After a write of value V to offset 0x04, a read of 0x04 returns ~V.
- R3: A write of n to offset 0x08 while idle makes 0x08 hold n! modulo 2^32. Both n=0 and n=1 yield 1.
- R4: Status bit 0 at offset 0x20 reads 1 from the edge that accepts the operand write until the result is in 0x08. This takes max(n,1) cycles, and the result is readable in the first cycle that bit 0 reads 0.
- R5: A write to 0x08 while bit 0 of 0x20 is 1 is ignored. It changes neither the result nor the completion time.
- R6: A write to 0x20 changes only bit 7, the completion-interrupt enable. Bit 0 ignores writes, and all other bits read 0.
- R7: `done_pulse` is high for exactly one cycle, in the first cycle in which the busy bit reads 0 after a computation.
- R8: When bit 7 of 0x20 is 1 during the `done_pulse` cycle, bit 0 of the interrupt status at 0x24 becomes 1 on the next edge. With bit 7 at 0 it stays 0. `irq` is high whenever any bit of 0x24 is 1.
- R9: Writing a mask to offset 0x64 clears those bits of 0x24 on the next edge. A set and a clear of the same bit on the same edge leave the bit set.
- R10: After reset, 0x04, 0x08, 0x20 and 0x24 read 0 and `irq` and `done_pulse` are low. Reads of offsets that are not mapped return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Byte offset of the read |
| rd_data | output | 32 | Read data, combinational on rd_addr |
| done_pulse | output | 1 | One-cycle completion strobe |
| irq | output | 1 | Level interrupt, OR of the interrupt status bits |

## Verification
The hardest case to reach from the ports is an acknowledge that lands on the same edge as a new completion. The bench watches `done_pulse` at the falling edge and puts the acknowledge write on the bus in that same cycle, so the set and the clear meet on one edge. A second timing case is a write to the operand register that arrives while the engine is running. The bench issues it one cycle after the start and then checks both the value and the latency recorded by the scoreboard.

// File: rtl/fu_pkg.sv
package fu_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_IDENT = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_LIVE  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_OPRES = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_ISTAT = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_IACK  = 8'h64;

  localparam int unsigned BUSY_BIT = 0;
  localparam int unsigned IEN_BIT  = 7;
  localparam logic [7:0]  IDENT_TAG = 8'hED;
endpackage

// File: rtl/fu_engine.sv
module fu_engine #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] operand_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] value_o
);
  logic [W-1:0] acc_q, cnt_q, value_q;
  logic         busy_q, done_q;
  logic         last_step;

  assign last_step = (cnt_q <= W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      cnt_q   <= '0;
      value_q <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        if (last_step) begin
          value_q <= acc_q;
          busy_q  <= 1'b0;
          done_q  <= 1'b1;
        end else begin
          acc_q <= acc_q * cnt_q;
          cnt_q <= cnt_q - W'(1);
        end
      end else if (start_i) begin
        value_q <= operand_i;
        acc_q   <= W'(1);
        cnt_q   <= operand_i;
        busy_q  <= 1'b1;
      end
    end
  end

  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign value_o = value_q;

  // R4
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last_step) |=> busy_q);
  // R5
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_q && !last_step) |=> $stable(value_q));
  // R7
  done_follows_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);
  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/fu_irq.sv
module fu_irq #(
  parameter int unsigned NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_i,
  input  logic            ack_we_i,
  input  logic [NSRC-1:0] ack_mask_i,
  output logic [NSRC-1:0] status_o,
  output logic            irq_o
);
  logic [NSRC-1:0] stat_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          stat_q[i] <= 1'b0;
      else if (set_i[i])                   stat_q[i] <= 1'b1;
      else if (ack_we_i && ack_mask_i[i])  stat_q[i] <= 1'b0;
    end

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> stat_q[i]);
    // R9
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_we_i && ack_mask_i[i] && !set_i[i]) |=> !stat_q[i]);
  end

  assign status_o = stat_q;
  assign irq_o    = |stat_q;
endmodule

// File: rtl/fu_readmux.sv
module fu_readmux
  import fu_pkg::*;
#(
  parameter logic [7:0] VER_MAJOR = 8'h01,
  parameter logic [7:0] VER_MINOR = 8'h00
) (
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [DATA_W-1:0] live_i,
  input  logic [DATA_W-1:0] opres_i,
  input  logic              busy_i,
  input  logic              ien_i,
  input  logic [7:0]        istat_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam logic [DATA_W-1:0] IDENT_WORD = {VER_MAJOR, VER_MINOR, 8'h00, IDENT_TAG};

  logic [DATA_W-1:0] stat_word;

  always_comb begin
    stat_word           = '0;
    stat_word[BUSY_BIT] = busy_i;
    stat_word[IEN_BIT]  = ien_i;
  end

  always_comb begin
    unique case (rd_addr_i)
      OFS_IDENT: rd_data_o = IDENT_WORD;
      OFS_LIVE:  rd_data_o = live_i;
      OFS_OPRES: rd_data_o = opres_i;
      OFS_STAT:  rd_data_o = stat_word;
      OFS_ISTAT: rd_data_o = {{(DATA_W-8){1'b0}}, istat_i};
      default:   rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/factorial_unit.sv
module factorial_unit
  import fu_pkg::*;
#(
  parameter logic [7:0] VER_MAJOR = 8'h01,
  parameter logic [7:0] VER_MINOR = 8'h00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [7:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        done_pulse,
  output logic        irq
);
  localparam int unsigned NIRQ = 8;

  logic [DATA_W-1:0] live_q;
  logic              ien_q;
  logic              busy, done;
  logic [DATA_W-1:0] opres;
  logic [NIRQ-1:0]   istat, irq_set;
  logic              wr_live, wr_opres, wr_stat, wr_iack;

  assign wr_live  = wr_en && (wr_addr == OFS_LIVE);
  assign wr_opres = wr_en && (wr_addr == OFS_OPRES);
  assign wr_stat  = wr_en && (wr_addr == OFS_STAT);
  assign wr_iack  = wr_en && (wr_addr == OFS_IACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
      ien_q  <= 1'b0;
    end else begin
      if (wr_live) live_q <= ~wr_data;
      if (wr_stat) ien_q  <= wr_data[IEN_BIT];
    end
  end

  fu_engine #(.W(DATA_W)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (wr_opres),
    .operand_i (wr_data),
    .busy_o    (busy),
    .done_o    (done),
    .value_o   (opres)
  );

  assign irq_set = {{(NIRQ-1){1'b0}}, done & ien_q};

  fu_irq #(.NSRC(NIRQ)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (irq_set),
    .ack_we_i   (wr_iack),
    .ack_mask_i (wr_data[NIRQ-1:0]),
    .status_o   (istat),
    .irq_o      (irq)
  );

  fu_readmux #(.VER_MAJOR(VER_MAJOR), .VER_MINOR(VER_MINOR)) u_rdmux (
    .rd_addr_i (rd_addr),
    .live_i    (live_q),
    .opres_i   (opres),
    .busy_i    (busy),
    .ien_i     (ien_q),
    .istat_i   (istat),
    .rd_data_o (rd_data)
  );

  assign done_pulse = done;

  // R2
  live_inverts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_live |=> (live_q == ~$past(wr_data)));
  // R6
  ien_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stat |=> $stable(ien_q));
  // R8
  irq_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ien_q) |=> irq);
endmodule

// File: tb/factorial_unit_bench.sv
module factorial_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        done_pulse, irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  logic [31:0] exp_val_q[$];
  int          exp_lat_q[$];
  int          start_cyc_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  factorial_unit u_factorial_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .done_pulse(done_pulse), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] fact_ref(input logic [31:0] n);
    logic [31:0] r = 32'd1;
    for (int k = 2; k <= int'(n); k++) r = r * 32'(k);
    return r;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  // driver: start a computation and push the expected result and latency
  task automatic start_fact(input logic [31:0] n);
    rd_addr = 8'h08;
    exp_val_q.push_back(fact_ref(n));
    exp_lat_q.push_back((n > 1) ? int'(n) : 1);
    start_cyc_q.push_back(cyc);
    wr(8'h08, n);
  endtask

  task automatic wait_drained();
    while (exp_val_q.size() != 0) @(negedge clk);
  endtask

  // monitor: at the completion strobe compare 0x08 and the latency
  always @(negedge clk) begin
    if (rst_n && done_pulse) begin
      if (exp_val_q.size() == 0) begin
        check("R7 unexpected done", 32'd1, 32'd0);
      end else begin
        logic [31:0] ev;
        int el, sc;
        ev = exp_val_q.pop_front();
        el = exp_lat_q.pop_front();
        sc = start_cyc_q.pop_front();
        check("R3 result", rd_data, ev);
        check("R4 latency", 32'(cyc - sc - 1), 32'(el));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    rd(8'h04, v); check("R10 live reset", v, 32'h0);
    rd(8'h08, v); check("R10 opres reset", v, 32'h0);
    rd(8'h20, v); check("R10 status reset", v, 32'h0);
    rd(8'h24, v); check("R10 istat reset", v, 32'h0);
    check("R10 irq reset", {31'b0, irq}, 32'h0);
    check("R10 done reset", {31'b0, done_pulse}, 32'h0);
    rd(8'h44, v); check("R10 unmapped", v, 32'h0);

    // R1 identification, and a write to it has no effect
    rd(8'h00, v); check("R1 ident", v, 32'h010000ED);
    wr(8'h00, 32'h12345678);
    rd(8'h00, v); check("R1 ident after write", v, 32'h010000ED);

    // R2 liveness patterns
    wr(8'h04, 32'h00000000); rd(8'h04, v); check("R2 live zero", v, 32'hFFFFFFFF);
    wr(8'h04, 32'hA5A5F00F); rd(8'h04, v); check("R2 live pattern", v, 32'h5A5A0FF0);
    wr(8'h04, 32'hFFFFFFFF); rd(8'h04, v); check("R2 live ones", v, 32'h0);

    // R3 R4 factorials, including the 0/1 corner and wraparound
    start_fact(32'd0); wait_drained();
    start_fact(32'd1); wait_drained();
    start_fact(32'd5); wait_drained();
    start_fact(32'd12); wait_drained();
    start_fact(32'd13); wait_drained();
    rd(8'h08, v); check("R3 13! wrapped", v, 32'd1932053504);

    // R4 busy bit while running, clear after
    start_fact(32'd4);
    rd(8'h20, v); check("R4 busy set", v & 32'h1, 32'h1);
    rd_addr = 8'h08;
    wait_drained();
    rd(8'h20, v); check("R4 busy clear", v & 32'h1, 32'h0);

    // R5 write while busy ignored (latency also checked by monitor)
    start_fact(32'd6);
    wr(8'h08, 32'd3);
    rd_addr = 8'h08;
    wait_drained();
    rd(8'h08, v); check("R5 ignored write", v, 32'd720);

    // R6 only bit 7 writable
    wr(8'h20, 32'hFFFFFFFF); rd(8'h20, v); check("R6 write ones", v, 32'h80);
    wr(8'h20, 32'h00000001); rd(8'h20, v); check("R6 busy not writable", v, 32'h0);

    // R8 disabled: no interrupt status
    start_fact(32'd3); wait_drained();
    rd(8'h24, v); check("R8 disabled no istat", v, 32'h0);
    check("R8 disabled irq low", {31'b0, irq}, 32'h0);

    // R8 enabled, R7 pulse width, R6 bit 7 reads with busy
    wr(8'h20, 32'h80);
    start_fact(32'd3);
    rd(8'h20, v); check("R6 enable with busy", v, 32'h81);
    rd_addr = 8'h08;
    while (!done_pulse) @(negedge clk);
    @(negedge clk);
    check("R7 single cycle", {31'b0, done_pulse}, 32'h0);
    rd(8'h24, v); check("R8 istat set", v, 32'h1);
    check("R8 irq high", {31'b0, irq}, 32'h1);

    // R9 acknowledge clears
    wr(8'h64, 32'h1);
    rd(8'h24, v); check("R9 ack clears", v, 32'h0);
    check("R9 irq low", {31'b0, irq}, 32'h0);

    // R9 set and ack on the same edge: set wins
    start_fact(32'd2);
    rd_addr = 8'h08;
    while (!done_pulse) @(negedge clk);
    wr(8'h64, 32'h1);
    rd(8'h24, v); check("R9 set wins", v, 32'h1);
    wr(8'h64, 32'h1);
    rd(8'h24, v); check("R9 ack after", v, 32'h0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule